// File: doc/BRIEF.md
# Banked Register File Decoder

This block is the data memory of a small 8-bit microcontroller core. An access names a location either directly, as a 7-bit address from the instruction with a bank-select bit above it, or indirectly, through a full 8-bit pointer. The resulting 8-bit effective address is decoded into four kinds of region. The low 32 locations of each bank go out on a separate special-function port. There is general-purpose RAM private to each bank. A 16-byte window in bank 1 shares storage with the top of bank 0 RAM. The remaining holes read as zero.

Writes land on the rising clock edge while the write strobe is high. Reads are combinational from the stored contents, so a read and a write to the same location in one cycle return the old value. The block holds 96 bytes for bank 0 and 32 bytes for bank 1. The shared window adds no storage. Reset clears all of it.

Top module: `bank_regfile`

## Requirements
- R1: The effective address is {bank_sel, dir_addr} when ind_sel is 0 and ind_ptr when ind_sel is 1, and both sources follow the same decode rules; sfr_addr always shows the effective address.
- R2: Effective addresses with bits [6:5] equal to 00 (00h–1Fh and 80h–9Fh) are special-function locations. There, sfr_rd equals rd_en, sfr_wr equals wr_en, sfr_wdata carries wr_data, rd_data returns sfr_rdata, and no local storage changes. Outside this region, sfr_rd and sfr_wr stay 0.
- R3: Addresses 20h–7Fh are bank 0 general RAM. A write there is stored on the clock edge and read back afterwards.
- R4: Addresses A0h–BFh are bank 1 general RAM. This storage is separate from bank 0.
- R5: Addresses F0h–FFh reach the same bytes as 70h–7Fh, so a write through either address is seen through both.
- R6: Addresses C0h–EFh are unimplemented. They read as 0 and writes to them change no storage.
- R7: A read in the same cycle as a write to the same location returns the value held before that write.
- R8: While rd_en is 0, rd_data is 0.
- R9: After reset, every general RAM byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears storage |
| bank_sel | input | 1 | Bank-select bit, top of the direct effective address |
| dir_addr | input | 7 | Direct address from the instruction |
| ind_sel | input | 1 | 1 selects the indirect pointer as the address |
| ind_ptr | input | 8 | Indirect pointer |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| sfr_addr | output | 8 | Effective address forwarded to special-function logic |
| sfr_rd | output | 1 | Special-function read strobe |
| sfr_wr | output | 1 | Special-function write strobe |
| sfr_wdata | output | 8 | Special-function write data |
| sfr_rdata | input | 8 | Special-function read data |

## Verification
The bench targets the shared window from both sides. A design that decoded F0h–FFh as a hole or gave it separate bytes would return stale or zero data through the other alias. It writes into C0h–EFh and then reads back every byte. A decoder that let those writes through would corrupt bank 0 or bank 1 bytes, and the comparison against a bench model of all 128 bytes would catch that. It also reads and writes one address in the same cycle, where a write-through design would return the new value. Indirect pointers that cross banks exercise the effective-address source: a design that ignored ind_sel would hit the wrong bank or raise the special-function strobes at the wrong time.

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_sel,
  input  logic [AW-1:0] dir_addr,
  input  logic          ind_sel,
  input  logic [AW:0]   ind_ptr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   sfr_addr,
  output logic          sfr_rd,
  output logic          sfr_wr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata
);
  localparam int SFR_SPAN = 32;
  localparam int B0_WORDS = (1 << AW) - SFR_SPAN;
  localparam int B1_WORDS = SFR_SPAN;

  logic [DW-1:0] mem0 [B0_WORDS];
  logic [DW-1:0] mem1 [B1_WORDS];

  logic [AW:0]   ea;
  logic          hit_sfr, hit0, hit1;
  logic [AW-1:0] idx0;
  logic [4:0]    idx1;

  assign ea      = ind_sel ? ind_ptr : {bank_sel, dir_addr};
  assign hit_sfr = (ea[6:5] == 2'b00);
  assign hit0    = (!ea[7] && !hit_sfr) || (ea[7] && ea[6:4] == 3'b111);
  assign hit1    = ea[7] && (ea[6:5] == 2'b01);
  assign idx0    = ea[6:0] - AW'(SFR_SPAN);
  assign idx1    = ea[4:0];

  assign sfr_addr  = ea;
  assign sfr_rd    = rd_en && hit_sfr;
  assign sfr_wr    = wr_en && hit_sfr;
  assign sfr_wdata = wr_data;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (hit_sfr)   rd_data = sfr_rdata;
      else if (hit0) rd_data = mem0[idx0];
      else if (hit1) rd_data = mem1[idx1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < B0_WORDS; i++) mem0[i] <= '0;
      for (int i = 0; i < B1_WORDS; i++) mem1[i] <= '0;
    end else if (wr_en) begin
      if (hit0) mem0[idx0] <= wr_data;
      if (hit1) mem1[idx1] <= wr_data;
    end
  end
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bank_sel,
  input logic [6:0] dir_addr,
  input logic       ind_sel,
  input logic [7:0] ind_ptr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [7:0] sfr_addr,
  input logic       sfr_rd,
  input logic       sfr_wr,
  input logic [7:0] sfr_rdata
);
  AST_IND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ind_sel |-> sfr_addr == ind_ptr); // R1
  AST_SFR_WR_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_wr |-> sfr_addr[6:5] == 2'b00 && wr_en); // R2
  AST_SFR_RD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ind_sel && dir_addr[6:5] == 2'b00) |-> sfr_rd && rd_data == sfr_rdata); // R2
  AST_BANK0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ind_sel && !bank_sel && dir_addr[6:5] != 2'b00 &&
     $past(wr_en && !ind_sel && !bank_sel) && $past(dir_addr) == dir_addr)
    |-> rd_data == $past(wr_data)); // R3
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ind_sel && bank_sel && dir_addr[6:5] == 2'b11 && !dir_addr[4])
    |-> rd_data == 8'h00); // R6
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == 8'h00 && !sfr_rd); // R8
endmodule

bind bank_regfile bank_regfile_chk u_chk (.*);

// File: tb/bank_regfile_test.sv
module bank_regfile_test;
  logic clk = 0, rst_n = 0;
  logic bank_sel = 0, ind_sel = 0, rd_en = 0, wr_en = 0;
  logic [6:0] dir_addr = 0;
  logic [7:0] ind_ptr = 0, wr_data = 0, sfr_rdata = 0;
  logic [7:0] rd_data, sfr_addr, sfr_wdata;
  logic sfr_rd, sfr_wr;
  int compared = 0, mismatched = 0;
  logic [7:0] m0 [96];
  logic [7:0] m1 [32];

  always #5 clk = ~clk;

  bank_regfile uut (.*);

  function automatic int region(input logic [7:0] a); // 0 sfr,1 b0,2 b1,3 alias,4 hole
    if (a[6:5] == 2'b00) return 0;
    if (!a[7]) return 1;
    if (a[6:5] == 2'b01) return 2;
    if (a[6:4] == 3'b111) return 3;
    return 4;
  endfunction

  function automatic string tag(input logic [7:0] a);
    case (region(a))
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [7:0] model_rd(input logic [7:0] a, input logic r, input logic [7:0] s);
    if (!r) return 8'h00;
    case (region(a))
      0: return s;
      1, 3: return m0[a[6:0] - 7'd32];
      2: return m1[a[4:0]];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic op(input logic ind, input logic [7:0] a, input logic r, input logic w,
                    input logic [7:0] d, input string req);
    logic [7:0] ea, s;
    @(negedge clk);
    ind_sel = ind;
    ind_ptr = ind ? a : 8'($urandom);
    bank_sel = ind ? 1'($urandom) : a[7];
    dir_addr = ind ? 7'($urandom) : a[6:0];
    rd_en = r; wr_en = w; wr_data = d;
    s = 8'($urandom); sfr_rdata = s;
    ea = a;
    #1;
    chk({req, " rd_data"}, rd_data, model_rd(ea, r, s));
    chk("R1 sfr_addr", sfr_addr, ea);
    chk("R2 sfr strobes", {6'd0, sfr_rd, sfr_wr},
        {6'd0, r && region(ea) == 0, w && region(ea) == 0});
    if (w && region(ea) == 0) chk("R2 sfr_wdata", sfr_wdata, d);
    @(posedge clk); #1;
    if (w) case (region(ea))
      1, 3: m0[ea[6:0] - 7'd32] = d;
      2: m1[ea[4:0]] = d;
      default: ;
    endcase
    rd_en = 0; wr_en = 0;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 256; a++)
      if (region(8'(a)) != 0) op(0, 8'(a), 1, 0, 0, req);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 96; i++) m0[i] = 0;
    for (int i = 0; i < 32; i++) m1[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sweep("R9 reset");
    op(0, 8'h42, 0, 0, 0, "R8 idle");
    op(0, 8'h75, 0, 1, 8'h5A, "R5 write");
    op(0, 8'hF5, 1, 0, 0, "R5 alias read");
    op(0, 8'hFA, 0, 1, 8'hC3, "R5 write hi");
    op(0, 8'h7A, 1, 0, 0, "R5 alias read lo");
    op(0, 8'h21, 0, 1, 8'h11, "R3 write");
    op(0, 8'hA1, 0, 1, 8'h22, "R4 write");
    op(0, 8'h21, 1, 0, 0, "R3 separate");
    op(0, 8'hA1, 1, 0, 0, "R4 separate");
    op(0, 8'h30, 0, 1, 8'h01, "R7 setup");
    op(0, 8'h30, 1, 1, 8'h02, "R7 old value");
    op(0, 8'h30, 1, 0, 0, "R7 new value");
    op(1, 8'hA7, 0, 1, 8'h99, "R1 indirect write");
    op(0, 8'hA7, 1, 0, 0, "R1 direct read");
    op(0, 8'h05, 1, 1, 8'h77, "R2 sfr");
    op(0, 8'h85, 1, 1, 8'h66, "R2 sfr bank1");
    for (int a = 8'hC0; a < 8'hF0; a++) op(0, 8'(a), 0, 1, 8'hFF, "R6 write hole");
    op(0, 8'hC4, 1, 0, 0, "R6 hole read");
    sweep("R6 storage intact");
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = 8'($urandom);
      op(1'($urandom), a, 1'($urandom), 1'($urandom), 8'($urandom), tag(a));
    end
    sweep("R3 final");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule